// File: doc/BRIEF.md
# Pointer-Addressed Register Bank Target on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C, 7-bit addressing). It holds a small bank of 8-bit control registers. The bank is reached through an internal register pointer. A fast system clock samples the bus clock and data lines. The block pulls the data line low through an output-enable signal, and the pad pulls the line low whenever that enable is high. The register contents are presented as one flat parallel output, so that the logic around the block can use the settings directly.

A controller writes by sending the target's address with the direction bit cleared. The next byte sets the pointer, and any further bytes fill consecutive registers. To read, the controller sends the address with the direction bit set, and the target streams bytes starting at the pointer. The start point of a read depends on how the frame began. After a plain START the read begins at register 0. After a repeated START that follows a pointer write, the read begins at the register that was just selected.

Top module: `i2c_regbank_target`

## Requirements
- R1: An address byte whose upper seven bits equal the parameter `DEV_ADDR` is acknowledged (SDA low on the 9th clock) for either direction bit. The direction bit is bit 0: 0 means write, 1 means read. Any other address gets no acknowledge, and the target then leaves SDA alone until the next START or STOP.
- R2: In a write frame, the first byte after the address is acknowledged and loads the pointer.
- R3: Each later byte in a write frame is acknowledged and stored in the register the pointer selects. The pointer then advances by one. Register n appears on `regs_o[8n+7:8n]`, and registers change only through such writes.
- R4: Pointer values 10 to 15 are reserved. Writes to them are acknowledged and discarded, and reads from them return 0x00. A pointer byte above 15 loads 15. The pointer stops at 15 and never wraps.
- R5: A read that follows a START on an idle bus (after reset or after a STOP) begins at register 0.
- R6: A read that follows a repeated START, inside a frame that has already set the pointer, begins at that pointer. The pointer advances after each byte sent.
- R7: The target changes SDA only while SCL is low. The level it drives stays constant for the whole high phase of SCL.
- R8: When the controller answers a read byte with a NACK (SDA high on the 9th clock), the target releases SDA and drives nothing more until the next START or STOP.
- R9: A START or a STOP seen at any bit position abandons the byte in progress. A partly received byte is never written.
- R10: After reset, all registers read 0x00, the pointer is 0 and SDA is released.
- R11: A STOP always releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| regs_o | output | NREGS*8 | All registers side by side, register n in bits [8n+7:8n] |

## Verification
The hardest case to reach from the ports is a read that must start at a preset pointer. That needs a write frame which stops after the pointer byte, then a repeated START with no STOP in between, then a read address. Saturation adds a second hard case, because it only shows up for pointer values at the top of the range. The bench sweeps every pointer byte from 0 to 17 through this exact sequence. For each value it reads three bytes, so the 9-to-10 reserved boundary and the stop at 15 are both crossed. The bench then issues a plain START read to show that the preset does not carry over a STOP. Aborts are reached by sending only a few bits of a data byte and then inserting a repeated START or a STOP at that point.

// File: rtl/i2crb_pkg.sv
package i2crb_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK,
    ST_HALT
  } state_e;

endpackage

// File: rtl/i2crb_busmon.sv
module i2crb_busmon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] scl_sh_q, sda_sh_q;
  logic [DEPTH-1:0] scl_sh_d, sda_sh_d;
  logic             scl_q, sda_q;

  always_comb begin
    scl_sh_d = {scl_sh_q[DEPTH-2:0], scl_i};
    sda_sh_d = {sda_sh_q[DEPTH-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q <= '1;
      sda_sh_q <= '1;
    end else begin
      scl_sh_q <= scl_sh_d;
      sda_sh_q <= sda_sh_d;
    end
  end

  assign scl_s = scl_sh_q[SYNC_STAGES-1];
  assign sda_s = sda_sh_q[SYNC_STAGES-1];
  assign scl_q = scl_sh_q[SYNC_STAGES];
  assign sda_q = sda_sh_q[SYNC_STAGES];

  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/i2crb_regfile.sv
module i2crb_regfile #(
  parameter int NREGS = 10,
  parameter int AW    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [i2crb_pkg::BYTE_W-1:0]  wr_data,
  input  logic [AW-1:0]                 rd_addr,
  output logic [i2crb_pkg::BYTE_W-1:0]  rd_data,
  output logic [NREGS*i2crb_pkg::BYTE_W-1:0] regs_o
);

  localparam int BW = i2crb_pkg::BYTE_W;

  logic [BW-1:0] bank_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[g] <= '0;
      end else if (hit) begin
        bank_q[g] <= wr_data;
      end
    end

    assign regs_o[g*BW +: BW] = bank_q[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (rd_addr == AW'(i)) rd_data = bank_q[i];
    end
  end

endmodule

// File: rtl/i2crb_engine.sv
module i2crb_engine
  import i2crb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h4D,
  parameter int         AW       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [AW-1:0]     ptr_o,
  output logic              sda_oe,
  output state_e            state_o
);

  localparam logic [AW-1:0]     PTR_MAX  = '1;
  localparam logic [BYTE_W-1:0] PTR_CAP  = BYTE_W'(PTR_MAX);
  localparam logic [2:0]        LAST_BIT = 3'd7;

  state_e            state_q, state_d;
  logic [2:0]        bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [BYTE_W-1:0] txbuf_q, txbuf_d;
  logic [AW-1:0]     ptr_q, ptr_d;
  logic              full_q, full_d;
  logic              hi_q, hi_d;
  logic              rw_q, rw_d;
  logic              match_q, match_d;
  logic              preset_q, preset_d;
  logic              mack_q, mack_d;
  logic              oe_q, oe_d;
  logic [BYTE_W-1:0] byte_in;
  logic              byte_end;

  function automatic logic [AW-1:0] sat_inc(input logic [AW-1:0] p);
    return (p == PTR_MAX) ? p : p + 1'b1;
  endfunction

  assign byte_in  = {shreg_q[BYTE_W-2:0], sda_s};
  assign byte_end = scl_rise && !full_q && (bitcnt_q == LAST_BIT);

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    txbuf_d  = txbuf_q;
    ptr_d    = ptr_q;
    full_d   = full_q;
    hi_d     = hi_q;
    rw_d     = rw_q;
    match_d  = match_q;
    preset_d = preset_q;
    mack_d   = mack_q;
    oe_d     = oe_q;
    wr_en    = 1'b0;
    wr_addr  = ptr_q;
    wr_data  = byte_in;

    if (start_det) begin
      state_d  = ST_ADDR;
      bitcnt_d = '0;
      full_d   = 1'b0;
      oe_d     = 1'b0;
    end else if (stop_det) begin
      state_d  = ST_IDLE;
      bitcnt_d = '0;
      full_d   = 1'b0;
      oe_d     = 1'b0;
      preset_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          oe_d = 1'b0;
        end

        ST_HALT: begin
          oe_d = 1'b0;
        end

        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise && !full_q) begin
            shreg_d  = byte_in;
            bitcnt_d = bitcnt_q + 3'd1;
          end
          if (byte_end) begin
            full_d = 1'b1;
            if (state_q == ST_ADDR) begin
              match_d = (byte_in[BYTE_W-1:1] == DEV_ADDR);
              rw_d    = byte_in[0];
              if ((byte_in[BYTE_W-1:1] == DEV_ADDR) && byte_in[0] && !preset_q)
                ptr_d = '0;
            end else if (state_q == ST_PTR) begin
              ptr_d    = (byte_in > PTR_CAP) ? PTR_MAX : byte_in[AW-1:0];
              preset_d = 1'b1;
            end else begin
              wr_en = 1'b1;
              ptr_d = sat_inc(ptr_q);
            end
          end
          if (scl_fall && full_q) begin
            full_d   = 1'b0;
            hi_d     = 1'b0;
            bitcnt_d = '0;
            if (state_q == ST_ADDR) begin
              if (match_q) begin
                state_d = ST_ADDR_ACK;
                oe_d    = 1'b1;
              end else begin
                state_d = ST_HALT;
                oe_d    = 1'b0;
              end
            end else if (state_q == ST_PTR) begin
              state_d = ST_PTR_ACK;
              oe_d    = 1'b1;
            end else begin
              state_d = ST_WDATA_ACK;
              oe_d    = 1'b1;
            end
          end
        end

        ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: begin
          if (scl_rise) hi_d = 1'b1;
          if (scl_fall && hi_q) begin
            hi_d     = 1'b0;
            bitcnt_d = '0;
            oe_d     = 1'b0;
            if (state_q == ST_ADDR_ACK && rw_q) begin
              state_d = ST_RDATA;
              txbuf_d = rd_data;
              oe_d    = ~rd_data[BYTE_W-1];
            end else if (state_q == ST_ADDR_ACK) begin
              state_d = ST_PTR;
            end else begin
              state_d = ST_WDATA;
            end
          end
        end

        ST_RDATA: begin
          if (scl_fall) begin
            if (bitcnt_q == LAST_BIT) begin
              state_d  = ST_RDATA_ACK;
              bitcnt_d = '0;
              hi_d     = 1'b0;
              oe_d     = 1'b0;
              ptr_d    = sat_inc(ptr_q);
            end else begin
              bitcnt_d = bitcnt_q + 3'd1;
              txbuf_d  = {txbuf_q[BYTE_W-2:0], 1'b0};
              oe_d     = ~txbuf_q[BYTE_W-2];
            end
          end
        end

        ST_RDATA_ACK: begin
          if (scl_rise) begin
            hi_d   = 1'b1;
            mack_d = ~sda_s;
          end
          if (scl_fall && hi_q) begin
            hi_d = 1'b0;
            if (mack_q) begin
              state_d  = ST_RDATA;
              bitcnt_d = '0;
              txbuf_d  = rd_data;
              oe_d     = ~rd_data[BYTE_W-1];
            end else begin
              state_d = ST_HALT;
              oe_d    = 1'b0;
            end
          end
        end

        default: begin
          state_d = ST_IDLE;
          oe_d    = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      txbuf_q  <= '0;
      ptr_q    <= '0;
      full_q   <= 1'b0;
      hi_q     <= 1'b0;
      rw_q     <= 1'b0;
      match_q  <= 1'b0;
      preset_q <= 1'b0;
      mack_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      txbuf_q  <= txbuf_d;
      ptr_q    <= ptr_d;
      full_q   <= full_d;
      hi_q     <= hi_d;
      rw_q     <= rw_d;
      match_q  <= match_d;
      preset_q <= preset_d;
      mack_q   <= mack_d;
      oe_q     <= oe_d;
    end
  end

  assign ptr_o   = ptr_q;
  assign sda_oe  = oe_q;
  assign state_o = state_q;

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
  import i2crb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h4D,
  parameter int         NREGS       = 10,
  parameter int         AW          = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scl_i,
  input  logic                      sda_i,
  output logic                      sda_oe_o,
  output logic [NREGS*BYTE_W-1:0]   regs_o
);

  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [AW-1:0]     wr_addr, ptr;
  logic [BYTE_W-1:0] wr_data, rd_data;
  state_e            eng_state;

  i2crb_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_busmon (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2crb_engine #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ptr_o     (ptr),
    .sda_oe    (sda_oe_o),
    .state_o   (eng_state)
  );

  i2crb_regfile #(.NREGS(NREGS), .AW(AW)) u_regfile (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (ptr),
    .rd_data (rd_data),
    .regs_o  (regs_o)
  );

endmodule

// File: rtl/i2crb_checker.sv
module i2crb_checker
  import i2crb_pkg::*;
#(
  parameter int NREGS = 10,
  parameter int AW    = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    scl_s,
  input logic                    start_det,
  input logic                    stop_det,
  input logic                    sda_oe,
  input logic                    wr_en,
  input logic [AW-1:0]           wr_addr,
  input logic [NREGS*BYTE_W-1:0] regs,
  input state_e                  state
);

  AST_OE_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe)); // R7

  AST_REGS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs)); // R3

  AST_RESERVED_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr >= AW'(NREGS))) |=> $stable(regs)); // R4

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R11

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |-> !sda_oe); // R8

endmodule

bind i2c_regbank_target i2crb_checker #(.NREGS(NREGS), .AW(AW)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe_o),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .regs      (regs_o),
  .state     (eng_state)
);

// File: tb/i2c_regbank_target_bench.sv
module i2c_regbank_target_bench;

  localparam logic [6:0] DEV   = 7'h4D;
  localparam int         NREGS = 10;
  localparam int         Q     = 10;

  logic clk, rst_n, scl, m_low;
  logic sda;
  logic sda_oe;
  logic [NREGS*8-1:0] regs;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [7:0] model [NREGS];

  assign sda = ~(m_low | sda_oe);

  i2c_regbank_target #(.DEV_ADDR(DEV), .NREGS(NREGS)) u_i2c_regbank_target (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda),
    .sda_oe_o (sda_oe),
    .regs_o   (regs)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int salt);
    return 8'((i * 37 + 11 + salt * 91) & 255);
  endfunction

  function automatic logic [7:0] exp_at(input int idx);
    return (idx < NREGS) ? model[idx] : 8'h00;
  endfunction

  task automatic bus_start();
    if (!scl) begin
      m_low = 1'b0; wt(Q);
      scl = 1'b1;   wt(Q);
    end
    m_low = 1'b1; wt(Q);
    scl = 1'b0;   wt(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wt(Q);
    scl = 1'b1;   wt(Q);
    m_low = 1'b0; wt(2*Q);
  endtask

  task automatic bit_xfer(input bit b, output bit r);
    m_low = ~b; wt(Q);
    scl = 1'b1; wt(Q);
    r = sda;    wt(Q);
    scl = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) bit_xfer(v[i], r);
    bit_xfer(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] v);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, r);
      v[i] = r;
    end
    bit_xfer(~give_ack, r);
  endtask

  task automatic check_bank(input string tag);
    for (int i = 0; i < NREGS; i++)
      chk(regs[i*8 +: 8] == model[i], tag, int'(regs[i*8 +: 8]), int'(model[i]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] v;
    scl = 1'b1; m_low = 1'b0; rst_n = 1'b0;
    for (int i = 0; i < NREGS; i++) model[i] = 8'h00;
    wt(5);
    rst_n = 1'b1;
    wt(5);

    // R10: reset state
    chk(regs == '0, "R10 regs after reset", int'(regs[31:0]), 0);
    chk(sda_oe == 1'b0, "R10 sda released", int'(sda_oe), 0);

    // R5/R1: read right after reset starts at register 0
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    chk(ack, "R1 read address ack", int'(ack), 1);
    recv_byte(1'b1, v); chk(v == 8'h00, "R5 first byte after reset", int'(v), 0);
    recv_byte(1'b0, v); chk(v == 8'h00, "R5 second byte after reset", int'(v), 0);
    bus_stop();
    chk(sda_oe == 1'b0, "R11 released after stop", int'(sda_oe), 0);

    // R2/R3/R4: burst write from pointer 0 running past the bank end
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk(ack, "R1 write address ack", int'(ack), 1);
    send_byte(8'h00, ack);
    chk(ack, "R2 pointer byte ack", int'(ack), 1);
    for (int i = 0; i < 18; i++) begin
      send_byte(pat(i, 0), ack);
      chk(ack, (i < NREGS) ? "R3 data byte ack" : "R4 reserved write ack", int'(ack), 1);
      if (i < NREGS) model[i] = pat(i, 0);
    end
    bus_stop();
    check_bank("R3 R4 bank after burst write");

    // R5/R4: plain START read streams whole range with saturation
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    for (int i = 0; i < 18; i++) begin
      recv_byte(i != 17, v);
      chk(v == exp_at((i > 15) ? 15 : i), "R5 R4 sequential read", int'(v),
          int'(exp_at((i > 15) ? 15 : i)));
    end
    bus_stop();

    // R6/R4: every pointer preset through repeated START
    for (int p = 0; p < 18; p++) begin
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'(p), ack);
      chk(ack, "R2 preset pointer ack", int'(ack), 1);
      bus_start();
      send_byte({DEV, 1'b1}, ack);
      chk(ack, "R1 read after repeated start ack", int'(ack), 1);
      for (int k = 0; k < 3; k++) begin
        int idx;
        idx = ((p > 15) ? 15 : p) + k;
        if (idx > 15) idx = 15;
        recv_byte(k != 2, v);
        chk(v == exp_at(idx), "R6 R4 preset read", int'(v), int'(exp_at(idx)));
      end
      bus_stop();
    end

    // R5: STOP forgets the preset pointer
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'd7, ack);
    bus_stop();
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    recv_byte(1'b0, v);
    chk(v == model[0], "R5 read after stop starts at 0", int'(v), int'(model[0]));
    bus_stop();

    // R1: wrong address is not acknowledged and its frame is ignored
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, ack);
    chk(!ack, "R1 foreign address nack", int'(ack), 0);
    send_byte(8'h02, ack);
    chk(!ack, "R1 ignored byte nack", int'(ack), 0);
    send_byte(8'hA5, ack);
    bus_stop();
    check_bank("R1 bank untouched by foreign frame");

    // R3: single-register writes at each pointer
    for (int r = 0; r < NREGS; r++) begin
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'(r), ack);
      send_byte(pat(r, 1), ack);
      chk(ack, "R3 single write ack", int'(ack), 1);
      model[r] = pat(r, 1);
      bus_stop();
    end
    check_bank("R3 bank after single writes");

    // R9: repeated START in the middle of a data byte
    begin
      bit r;
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'd3, ack);
      for (int i = 0; i < 4; i++) bit_xfer(i[0], r);
      bus_start();
      bus_stop();
      chk(regs[3*8 +: 8] == model[3], "R9 restart abort", int'(regs[3*8 +: 8]), int'(model[3]));
      // R9: STOP in the middle of a data byte
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'd4, ack);
      for (int i = 0; i < 5; i++) bit_xfer(~i[0], r);
      bus_stop();
      chk(regs[4*8 +: 8] == model[4], "R9 stop abort", int'(regs[4*8 +: 8]), int'(model[4]));
    end

    // R8: after a NACK the target drives nothing
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    recv_byte(1'b0, v);
    chk(v == model[0], "R6 single byte read", int'(v), int'(model[0]));
    recv_byte(1'b0, v);
    chk(v == 8'hFF, "R8 line idle after nack", int'(v), 255);
    chk(sda_oe == 1'b0, "R8 sda released after nack", int'(sda_oe), 0);
    bus_stop();

    // R10: reset during operation clears the bank
    rst_n = 1'b0; wt(3);
    for (int i = 0; i < NREGS; i++) model[i] = 8'h00;
    rst_n = 1'b1; wt(3);
    check_bank("R10 bank after reset");
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    recv_byte(1'b0, v);
    chk(v == 8'h00, "R10 pointer zero after reset", int'(v), 0);
    bus_stop();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule